// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block holds the operating mode of a clock generator and turns it into the select and enable lines that steer the clock generator's multiplexers. Software presents a set of control fields: a clock-source select, a reference select, a PLL select, a low-power bit, a fast/slow internal reference select, a PLL clock enable and an external reference divider code. These fields take effect only on a cycle where the write strobe is high. A field combination that matches a supported mode is accepted on that clock edge. Any other combination is refused and flagged.

Three modes are supported:
- **FLL engaged, internal reference.** This is the reset default. The output clock is taken from the FLL.
- **FLL engaged, external reference.** The output clock is taken from the FLL, and the FLL locks to the divided external reference.
- **FLL bypassed, internal reference.** The output clock is taken directly from the internal reference. The FLL keeps running on the slow internal reference, but its output is not used.

The PLL stays in low power in all three modes unless its dedicated clock enable is set.

While the external-reference mode is active, the block also checks the divided reference. The reference frequency arrives as a code in units of 15.625 Hz and is divided by a power of two. The block raises an error when the result falls outside the window the FLL can lock to.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns after that edge to the following state: `mode_o` = 00, `clk_out_sel` = 00, `fll_ref_ext` = 0, `irc_fast_sel` = 0, `pll_en` = 0, `illegal_wr` = 0, stored divider code 0.
- R2: A write with `src_sel` = 00, `ref_int` = 1 and `pll_sel` = 0 selects engaged-internal mode. From the next cycle, `mode_o` = 00. `lowpwr` is don't-care.
- R3: A write with `src_sel` = 00, `ref_int` = 0 and `pll_sel` = 0 selects engaged-external mode. From the next cycle, `mode_o` = 01. `lowpwr` is don't-care.
- R4: A write with `src_sel` = 01, `ref_int` = 1, `pll_sel` = 0 and `lowpwr` = 0 selects bypassed-internal mode. From the next cycle, `mode_o` = 10.
- R5: `clk_out_sel` depends on the mode. It is 00 (FLL output) in modes 00 and 01, and 01 (internal reference) in mode 10.
- R6: `fll_ref_ext` is 1 only in mode 01. In the other modes it is 0, meaning the FLL locks to the slow internal reference.
- R7: `irc_fast_sel` equals the `irc_fast` bit of the last accepted write. A value of 1 selects the 4 MHz internal reference and 0 selects the 32 kHz one.
- R8: `pll_en` equals the `pll_clk_en` bit of the last accepted write, and is 0 after reset in every mode.
- R9: `div_range_err` is 1 in the same cycle exactly when two conditions hold. First, `mode_o` = 01. Second, `ext_ref_code >> stored divider code` lies outside [2000, 2500], that is, outside 31.25 kHz to 39.0625 kHz in units of 15.625 Hz.
- R10: A write whose fields match none of R2 to R4 leaves the mode and all stored fields unchanged. `illegal_wr` is high in the cycle after that write, for that one cycle.
- R11: While `wr_en` is low, changes on the field inputs have no effect on any output except through `ext_ref_code` in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the field inputs |
| src_sel | input | 2 | Clock-source select field |
| ref_int | input | 1 | Reference select, 1 = internal |
| pll_sel | input | 1 | PLL select field |
| lowpwr | input | 1 | Low-power bit |
| irc_fast | input | 1 | Internal reference select, 1 = fast |
| pll_clk_en | input | 1 | PLL clock enable override |
| div_code | input | DIV_W (3) | External reference divider, divide by 2^code |
| ext_ref_code | input | REF_W (20) | External reference frequency, 15.625 Hz units |
| mode_o | output | 2 | Current mode: 00, 01 or 10 |
| clk_out_sel | output | 2 | Output clock mux select |
| fll_ref_ext | output | 1 | FLL reference mux, 1 = divided external |
| irc_fast_sel | output | 1 | Internal reference selector |
| pll_en | output | 1 | PLL enable, 0 = low power |
| div_range_err | output | 1 | Divided external reference out of window |
| illegal_wr | output | 1 | One-cycle flag for a refused write |

## Verification
The assertions check several relations on every cycle:
- The multiplexer selects agree with the mode: the internal reference drives the output in bypass, and the external reference feeds the FLL only in external mode.
- The range error can appear only in external mode.
- A refused write never moves the mode, and a refusal flag always follows a write.
- Nothing changes without a strobe.

Only the bench can show the rest:
- that each field combination decodes to the right mode;
- that the don't-care of the low-power bit applies in the engaged modes;
- that the window edges at 2000 and 2500 after the shift are inclusive;
- that refused writes keep the divider and enable bits as well as the mode.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   typedef enum logic [1:0] {
      MODE_ENG_INT = 2'b00,
      MODE_ENG_EXT = 2'b01,
      MODE_BYP_INT = 2'b10
   } cg_mode_e;

   localparam logic [1:0] OSEL_FLL  = 2'b00;
   localparam logic [1:0] OSEL_IREF = 2'b01;
endpackage

// File: rtl/clkgen_mode_decode.sv
module clkgen_mode_decode
   import clkgen_pkg::*;
(
   input  logic [1:0] src_sel,
   input  logic       ref_int,
   input  logic       pll_sel,
   input  logic       lowpwr,
   output logic       legal,
   output cg_mode_e   mode_nxt
);
   always_comb begin
      legal    = 1'b0;
      mode_nxt = MODE_ENG_INT;
      if (!pll_sel) begin
         if (src_sel == 2'b00) begin
            legal    = 1'b1;
            mode_nxt = ref_int ? MODE_ENG_INT : MODE_ENG_EXT;
         end else if (src_sel == 2'b01 && ref_int && !lowpwr) begin
            legal    = 1'b1;
            mode_nxt = MODE_BYP_INT;
         end
      end
   end
endmodule

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
   import clkgen_pkg::*;
#(
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             legal,
   input  cg_mode_e         mode_nxt,
   input  logic             irc_fast_in,
   input  logic             pll_clk_en_in,
   input  logic [DIV_W-1:0] div_in,
   output cg_mode_e         mode_q,
   output logic             irc_fast_q,
   output logic             pll_clk_en_q,
   output logic [DIV_W-1:0] div_q,
   output logic             illegal_q
);
   logic accept;
   assign accept = wr_en & legal;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q       <= MODE_ENG_INT;
         irc_fast_q   <= 1'b0;
         pll_clk_en_q <= 1'b0;
         div_q        <= '0;
         illegal_q    <= 1'b0;
      end else begin
         illegal_q <= wr_en & ~legal;
         if (accept) begin
            mode_q       <= mode_nxt;
            irc_fast_q   <= irc_fast_in;
            pll_clk_en_q <= pll_clk_en_in;
            div_q        <= div_in;
         end
      end
   end
endmodule

// File: rtl/clkgen_div_window.sv
module clkgen_div_window #(
   parameter int REF_W    = 20,
   parameter int DIV_W    = 3,
   parameter int WIN_LO   = 2000,
   parameter int WIN_HI   = 2500,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic [REF_W-1:0] ref_code,
   input  logic [DIV_W-1:0] div,
   input  logic             active,
   output logic             err
);
   localparam logic [REF_W-1:0] LO_V = REF_W'(WIN_LO);
   localparam logic [REF_W-1:0] HI_V = REF_W'(WIN_HI);

   generate
      if (CHECK_EN) begin : g_check
         logic [REF_W-1:0] divided;
         assign divided = ref_code >> div;
         assign err     = active & ((divided < LO_V) | (divided > HI_V));
      end else begin : g_nocheck
         logic unused_ok;
         assign unused_ok = ^{ref_code, div, active};
         assign err       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
   import clkgen_pkg::*;
#(
   parameter int REF_W    = 20,
   parameter int DIV_W    = 3,
   parameter int WIN_LO   = 2000,
   parameter int WIN_HI   = 2500,
   parameter bit CHECK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       src_sel,
   input  logic             ref_int,
   input  logic             pll_sel,
   input  logic             lowpwr,
   input  logic             irc_fast,
   input  logic             pll_clk_en,
   input  logic [DIV_W-1:0] div_code,
   input  logic [REF_W-1:0] ext_ref_code,
   output logic [1:0]       mode_o,
   output logic [1:0]       clk_out_sel,
   output logic             fll_ref_ext,
   output logic             irc_fast_sel,
   output logic             pll_en,
   output logic             div_range_err,
   output logic             illegal_wr
);
   localparam int MAX_SHIFT = (1 << DIV_W) - 1;

   generate
      if (DIV_W < 1 || DIV_W > 5) begin : g_bad_div
         $error("DIV_W must lie in 1..5");
      end
      if (REF_W < 2 || REF_W > 30 || WIN_HI >= (1 << REF_W)) begin : g_bad_ref
         $error("REF_W must hold WIN_HI");
      end
      if (WIN_LO > WIN_HI || WIN_LO < 1) begin : g_bad_win
         $error("window bounds out of order");
      end
      if (MAX_SHIFT >= REF_W) begin : g_bad_shift
         $error("divider shift exceeds reference width");
      end
   endgenerate

   logic             legal;
   cg_mode_e         mode_nxt;
   cg_mode_e         mode_q;
   logic             irc_fast_q;
   logic             pll_clk_en_q;
   logic [DIV_W-1:0] div_q;

   clkgen_mode_decode i_decode (
      .src_sel  (src_sel),
      .ref_int  (ref_int),
      .pll_sel  (pll_sel),
      .lowpwr   (lowpwr),
      .legal    (legal),
      .mode_nxt (mode_nxt)
   );

   clkgen_cfg_regs #(.DIV_W(DIV_W)) i_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .legal         (legal),
      .mode_nxt      (mode_nxt),
      .irc_fast_in   (irc_fast),
      .pll_clk_en_in (pll_clk_en),
      .div_in        (div_code),
      .mode_q        (mode_q),
      .irc_fast_q    (irc_fast_q),
      .pll_clk_en_q  (pll_clk_en_q),
      .div_q         (div_q),
      .illegal_q     (illegal_wr)
   );

   clkgen_div_window #(
      .REF_W(REF_W), .DIV_W(DIV_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .CHECK_EN(CHECK_EN)
   ) i_window (
      .ref_code (ext_ref_code),
      .div      (div_q),
      .active   (mode_q == MODE_ENG_EXT),
      .err      (div_range_err)
   );

   assign mode_o       = mode_q;
   assign clk_out_sel  = (mode_q == MODE_BYP_INT) ? OSEL_IREF : OSEL_FLL;
   assign fll_ref_ext  = (mode_q == MODE_ENG_EXT);
   assign irc_fast_sel = irc_fast_q;
   assign pll_en       = pll_clk_en_q;
endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] mode_o,
   input logic [1:0] clk_out_sel,
   input logic       fll_ref_ext,
   input logic       irc_fast_sel,
   input logic       pll_en,
   input logic       div_range_err,
   input logic       illegal_wr
);
   AST_BYPASS_IREF_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b10) |-> (clk_out_sel == 2'b01)); // R5
   AST_ENGAGED_FLL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'b10) |-> (clk_out_sel == 2'b00)); // R5
   AST_EXT_REF_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      fll_ref_ext |-> (mode_o == 2'b01)); // R6
   AST_RANGE_ERR_ONLY_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      div_range_err |-> (mode_o == 2'b01)); // R9
   AST_REFUSED_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_wr |-> ($stable(mode_o) && $stable(pll_en) && $stable(irc_fast_sel))); // R10
   AST_REFUSED_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_wr |-> $past(wr_en)); // R10
   AST_MODE_ENCODED: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o != 2'b11); // R10
   AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(mode_o) && $stable(pll_en) && $stable(irc_fast_sel) && !illegal_wr)); // R11
endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .mode_o        (mode_o),
   .clk_out_sel   (clk_out_sel),
   .fll_ref_ext   (fll_ref_ext),
   .irc_fast_sel  (irc_fast_sel),
   .pll_en        (pll_en),
   .div_range_err (div_range_err),
   .illegal_wr    (illegal_wr)
);

// File: tb/test_clkgen_mode_ctrl.sv
module test_clkgen_mode_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  src_sel = 2'b00;
   logic        ref_int = 1'b1;
   logic        pll_sel = 1'b0;
   logic        lowpwr = 1'b0;
   logic        irc_fast = 1'b0;
   logic        pll_clk_en = 1'b0;
   logic [2:0]  div_code = 3'd0;
   logic [19:0] ext_ref_code = 20'd0;
   logic [1:0]  mode_o, clk_out_sel;
   logic        fll_ref_ext, irc_fast_sel, pll_en, div_range_err, illegal_wr;

   int tests = 0;
   int fails = 0;

   // behavioural reference state
   int m_mode = 0, m_div = 0, m_fast = 0, m_pll = 0, m_ill = 0;

   always #5 clk = ~clk;

   clkgen_mode_ctrl i_clkgen_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .src_sel(src_sel), .ref_int(ref_int),
      .pll_sel(pll_sel), .lowpwr(lowpwr), .irc_fast(irc_fast), .pll_clk_en(pll_clk_en),
      .div_code(div_code), .ext_ref_code(ext_ref_code), .mode_o(mode_o),
      .clk_out_sel(clk_out_sel), .fll_ref_ext(fll_ref_ext), .irc_fast_sel(irc_fast_sel),
      .pll_en(pll_en), .div_range_err(div_range_err), .illegal_wr(illegal_wr)
   );

   always @(posedge clk) begin
      int nm;
      int ok;
      if (!rst_n) begin
         m_mode = 0; m_div = 0; m_fast = 0; m_pll = 0; m_ill = 0;
      end else begin
         ok = 0; nm = m_mode;
         if (pll_sel == 1'b0 && src_sel == 2'd0) begin ok = 1; nm = ref_int ? 0 : 1; end
         else if (pll_sel == 1'b0 && src_sel == 2'd1 && ref_int && !lowpwr) begin ok = 1; nm = 2; end
         m_ill = (wr_en && !ok) ? 1 : 0;
         if (wr_en && ok) begin
            m_mode = nm; m_div = div_code; m_fast = irc_fast; m_pll = pll_clk_en;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string tag);
      int q, e;
      q = int'(ext_ref_code) >> m_div;
      e = (m_mode == 1 && (q < 2000 || q > 2500)) ? 1 : 0;
      chk({tag, " mode R2 R3 R4"}, mode_o, m_mode);
      chk({tag, " R5 clk_out_sel"}, clk_out_sel, (m_mode == 2) ? 1 : 0);
      chk({tag, " R6 fll_ref_ext"}, fll_ref_ext, (m_mode == 1) ? 1 : 0);
      chk({tag, " R7 irc_fast_sel"}, irc_fast_sel, m_fast);
      chk({tag, " R8 pll_en"}, pll_en, m_pll);
      chk({tag, " R9 div_range_err"}, div_range_err, e);
      chk({tag, " R10 illegal_wr"}, illegal_wr, m_ill);
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic wr(input logic [1:0] s, input logic r, input logic p, input logic lp,
                     input logic f, input logic pe, input logic [2:0] d, input string tag);
      wr_en = 1'b1; src_sel = s; ref_int = r; pll_sel = p; lowpwr = lp;
      irc_fast = f; pll_clk_en = pe; div_code = d;
      step(tag);
      wr_en = 1'b0;
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      step("reset");
      step("reset");
      // R1: explicit reset values
      chk("R1 mode after reset", mode_o, 0);
      chk("R1 pll_en after reset", pll_en, 0);
      chk("R1 illegal after reset", illegal_wr, 0);
      rst_n = 1'b1;
      ext_ref_code = 20'd2200;
      step("idle");

      // R3: external engaged, in range and window edges (R9)
      wr(2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, "R3 to ext");
      chk("R3 mode ext", mode_o, 1);
      ext_ref_code = 20'd8000;  wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, "R9 lo edge");
      chk("R9 8000>>2 in window", div_range_err, 0);
      ext_ref_code = 20'd7999;  step("R9 below");
      chk("R9 7999>>2 low", div_range_err, 1);
      ext_ref_code = 20'd10003; step("R9 hi edge");
      chk("R9 10003>>2 at 2500", div_range_err, 0);
      ext_ref_code = 20'd10004; step("R9 above");
      chk("R9 10004>>2 high", div_range_err, 1);
      ext_ref_code = 20'd300000; wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, "R9 div128");
      chk("R9 300000>>7 in window", div_range_err, 0);

      // R11: field changes without strobe
      src_sel = 2'b01; ref_int = 1'b1; pll_clk_en = 1'b1; irc_fast = 1'b1; div_code = 3'd0;
      step("R11 no strobe"); step("R11 no strobe");
      chk("R11 mode held", mode_o, 1);
      chk("R11 pll held", pll_en, 0);

      // R4: bypassed internal with fast IRC and PLL enable (R7, R8)
      wr(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, "R4 to byp");
      chk("R4 mode byp", mode_o, 2);
      chk("R5 iref select", clk_out_sel, 1);
      chk("R7 fast irc", irc_fast_sel, 1);
      chk("R8 pll override", pll_en, 1);
      ext_ref_code = 20'd5; step("R9 not ext");

      // R10: refused writes keep everything
      wr(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, "R10 src10");
      chk("R10 pulse", illegal_wr, 1);
      chk("R10 mode kept", mode_o, 2);
      wr(2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd5, "R10 pll_sel");
      wr(2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, "R10 lowpwr byp");
      wr(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, "R10 byp ext ref");
      wr(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, "R10 src11");
      step("R10 pulse ends");
      chk("R10 single pulse", illegal_wr, 0);
      chk("R10 pll kept", pll_en, 1);

      // R2: back to engaged internal, lowpwr don't-care
      wr(2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3, "R2 to int");
      chk("R2 mode int", mode_o, 0);
      chk("R8 pll low", pll_en, 0);
      // back-to-back accepted writes
      wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, "R3 b2b");
      wr(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, "R4 b2b");
      chk("R7 slow irc", irc_fast_sel, 0);

      // R1: reset in the middle
      rst_n = 1'b0; step("R1 mid reset");
      chk("R1 mode reset", mode_o, 0);
      chk("R1 pll reset", pll_en, 0);
      rst_n = 1'b1;
      ext_ref_code = 20'd2200;
      wr(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, "R1 div cleared");
      for (int i = 0; i < 4; i++) step("tail");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule